// File: doc/BRIEF.md
# Ingress Packet Trace Filter

This block sits on the receive side of one switch port and inspects every arriving packet before the packet moves on. It holds the opening 160 bits of the packet, which is five 32-bit beats covering the header and the start of the payload. It tests that window against a small set of programmable entries. Each entry has its own pattern, its own care mask and its own enable bit.

If no enabled entry hits, the packet leaves unchanged. If an entry hits and tracing is on for this port, one global action is applied, chosen by a control bit. In copy mode, the packet is forwarded and its first beat is tagged with a copy request and the number of the trace port. In drop mode, the packet is taken from the input and nothing is sent out.

Both streams are 32-bit valid/ready streams with start-of-packet and end-of-packet markers. A write-only configuration port loads the patterns, masks and control fields. The actual duplication toward the trace port is done further down the fabric.

Top module: `trc_ingress_filter`

## Requirements
- R1: No output beat of a packet appears until its match decision exists. The decision is taken one cycle after the handshake of the fifth beat, or of an earlier end-of-packet beat. The first output beat is then valid in the cycle after that, and input is not accepted while buffered beats are being released.
- R2: Entry e hits when, for every window word w (beat w of the packet), `(beat ^ pattern[e][w]) & mask[e][w]` is zero.
- R3: The overall hit is the OR of the entries whose enable bit is set. An entry whose enable bit is clear never contributes, even if its pattern fits.
- R4: For a packet shorter than five beats, the missing window words compare as zero, and the decision follows its end-of-packet beat.
- R5: In copy mode (control bit 1 = 0), a hit forwards every beat unchanged, with `out_copy`=1 and `out_tport` set to the trace port field on the start beat.
- R6: In drop mode (control bit 1 = 1), a hit consumes every beat of the packet and no output beat is produced for it.
- R7: A packet with no hit is forwarded unchanged, with `out_copy`=0 and `out_tport`=0.
- R8: While the trace enable (control bit 0) is clear, no packet is tagged or dropped, whatever the entries hold.
- R9: `out_copy` and `out_tport` are zero on every output beat other than the start beat.
- R10: While `out_valid` is high and `out_ready` is low, the output beat and its sideband stay unchanged. No beat is lost, duplicated or reordered.
- R11: Beats after the window are passed straight through: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.
- R12: Configuration map. Address `e*16 + w` writes pattern word w of entry e, and `e*16 + 8 + w` writes its mask word, for w in 0..4. Address 64 is control: bit 0 trace enable, bit 1 drop mode, bits 11:8 trace port, bits 19:16 entry enables.
- R13: After reset, `out_valid` is 0, `in_ready` is 1, and all patterns, masks, enables and the trace port are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 32 | Input beat data |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | 32 | Output beat data |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_copy | output | 1 | Start beat carries a trace copy request |
| out_tport | output | 4 | Trace port number on the start beat |

## Verification
The decision is due one cycle after the last window beat is accepted, and the start beat is due one cycle after that. The bench samples one time unit before each rising edge and checks that `out_valid` is low at the first sample after the window closes and high, with start set, at the second.

Past the window, the output is combinational from the input on the same cycle. The bench therefore checks the pass-through relation at the very sample where the input is offered.

Every other result is checked as a handshake: a reference queue, filled when a packet is queued for sending, is compared against each output handshake as it happens. Stalled beats are compared with the previous sample on every clock.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef enum logic [2:0] {
      ST_FILL,
      ST_DEC,
      ST_EMIT,
      ST_PASS,
      ST_DISC
   } trc_state_e;

   localparam int unsigned CTL_EN_BIT   = 0;
   localparam int unsigned CTL_DROP_BIT = 1;
   localparam int unsigned CTL_PORT_LSB = 8;
   localparam int unsigned CTL_ENT_LSB  = 16;

endpackage

// File: rtl/trc_cfg_regs.sv
module trc_cfg_regs import trc_pkg::*; #(
   parameter int unsigned DW        = 32,
   parameter int unsigned WIN_BEATS = 5,
   parameter int unsigned N_ENT     = 4,
   parameter int unsigned PORT_W    = 4,
   parameter int unsigned WORD_AW   = 3,
   parameter int unsigned ADDR_W    = 7,
   localparam int unsigned N_WORDS  = N_ENT * WIN_BEATS,
   localparam int unsigned CTRL_A   = N_ENT << (WORD_AW + 1)
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [DW-1:0]                 wdata_i,
   output logic [N_WORDS*DW-1:0]         pat_o,
   output logic [N_WORDS*DW-1:0]         msk_o,
   output logic                          trace_en_o,
   output logic                          drop_mode_o,
   output logic [PORT_W-1:0]             tport_o,
   output logic [N_ENT-1:0]              ent_en_o
);

   function automatic logic [ADDR_W-1:0] word_addr(int unsigned e, int unsigned sel, int unsigned w);
      return ADDR_W'((e << (WORD_AW + 1)) | (sel << WORD_AW) | w);
   endfunction

   logic [DW-1:0] pat_q [N_WORDS];
   logic [DW-1:0] msk_q [N_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(N_WORDS); i++) begin
            pat_q[i] <= '0;
            msk_q[i] <= '0;
         end
         trace_en_o  <= 1'b0;
         drop_mode_o <= 1'b0;
         tport_o     <= '0;
         ent_en_o    <= '0;
      end else if (we_i) begin
         for (int e = 0; e < int'(N_ENT); e++) begin
            for (int w = 0; w < int'(WIN_BEATS); w++) begin
               if (addr_i == word_addr(e, 0, w)) pat_q[e*WIN_BEATS + w] <= wdata_i;
               if (addr_i == word_addr(e, 1, w)) msk_q[e*WIN_BEATS + w] <= wdata_i;
            end
         end
         if (addr_i == ADDR_W'(CTRL_A)) begin
            trace_en_o  <= wdata_i[CTL_EN_BIT];
            drop_mode_o <= wdata_i[CTL_DROP_BIT];
            tport_o     <= wdata_i[CTL_PORT_LSB +: PORT_W];
            ent_en_o    <= wdata_i[CTL_ENT_LSB +: N_ENT];
         end
      end
   end

   for (genvar i = 0; i < N_WORDS; i++) begin : g_flat
      assign pat_o[i*DW +: DW] = pat_q[i];
      assign msk_o[i*DW +: DW] = msk_q[i];
   end

endmodule

// File: rtl/trc_entry_cmp.sv
module trc_entry_cmp #(
   parameter int unsigned DW        = 32,
   parameter int unsigned WIN_BEATS = 5,
   localparam int unsigned WB       = DW * WIN_BEATS
)(
   input  logic [WB-1:0] win_i,
   input  logic [WB-1:0] pat_i,
   input  logic [WB-1:0] msk_i,
   input  logic          en_i,
   output logic          hit_o
);

   logic [WB-1:0] diff;

   assign diff  = (win_i ^ pat_i) & msk_i;
   assign hit_o = en_i && (diff == '0);

endmodule

// File: rtl/trc_hold_buf.sv
module trc_hold_buf #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 5,
   parameter int unsigned IDX_W = 3
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic [IDX_W-1:0]      wr_idx_i,
   input  logic [DW-1:0]         wr_data_i,
   input  logic                  wr_sop_i,
   input  logic                  wr_eop_i,
   input  logic [IDX_W-1:0]      rd_idx_i,
   output logic [DW-1:0]         rd_data_o,
   output logic                  rd_sop_o,
   output logic                  rd_eop_o,
   output logic [DEPTH*DW-1:0]   win_o
);

   logic [DW-1:0]    dat_q [DEPTH];
   logic [DEPTH-1:0] sop_q;
   logic [DEPTH-1:0] eop_q;

   // Starting a packet clears every slot so that unfilled window words read zero.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) dat_q[i] <= '0;
         sop_q <= '0;
         eop_q <= '0;
      end else if (wr_en_i) begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            if (wr_idx_i == IDX_W'(i)) begin
               dat_q[i] <= wr_data_i;
               sop_q[i] <= wr_sop_i;
               eop_q[i] <= wr_eop_i;
            end else if (wr_idx_i == '0) begin
               dat_q[i] <= '0;
               sop_q[i] <= 1'b0;
               eop_q[i] <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      rd_sop_o  = 1'b0;
      rd_eop_o  = 1'b0;
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (rd_idx_i == IDX_W'(i)) begin
            rd_data_o = dat_q[i];
            rd_sop_o  = sop_q[i];
            rd_eop_o  = eop_q[i];
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_win
      assign win_o[i*DW +: DW] = dat_q[i];
   end

endmodule

// File: rtl/trc_ingress_filter.sv
module trc_ingress_filter import trc_pkg::*; #(
   parameter int unsigned DW       = 32,
   parameter int unsigned WIN_BITS = 160,
   parameter int unsigned N_ENT    = 4,
   parameter int unsigned PORT_W   = 4,
   localparam int unsigned WIN_BEATS = WIN_BITS / DW,
   localparam int unsigned WORD_AW   = (WIN_BEATS > 1) ? $clog2(WIN_BEATS) : 1,
   localparam int unsigned CTRL_A    = N_ENT << (WORD_AW + 1),
   localparam int unsigned ADDR_W    = $clog2(CTRL_A + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DW-1:0]     cfg_wdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DW-1:0]     in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DW-1:0]     out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic              out_copy,
   output logic [PORT_W-1:0] out_tport
);

   localparam int unsigned WB    = WIN_BEATS * DW;
   localparam int unsigned CNT_W = $clog2(WIN_BEATS + 1);

   if (WIN_BITS % DW != 0) begin : g_chk_win
      $error("window width must be a whole number of beats");
   end
   if (N_ENT < 1 || N_ENT > 8) begin : g_chk_ent
      $error("entry count out of range");
   end
   if (DW < CTL_ENT_LSB + N_ENT || PORT_W > CTL_ENT_LSB - CTL_PORT_LSB) begin : g_chk_ctl
      $error("control fields do not fit the data width");
   end

   trc_state_e st;
   logic [CNT_W-1:0] wcnt, rcnt;
   logic             eop_held;
   logic             dec_copy;
   logic [PORT_W-1:0] tport_q;
   logic             dec_stb;

   logic [N_ENT*WB-1:0] pat_flat, msk_flat;
   logic                trace_en, drop_mode;
   logic [PORT_W-1:0]   cfg_tport;
   logic [N_ENT-1:0]    ent_en, hit;
   logic [WB-1:0]       win;
   logic [DW-1:0]       rd_data;
   logic                rd_sop, rd_eop;
   logic                buf_wr, do_match, do_drop, pkt_done;

   trc_cfg_regs #(
      .DW(DW), .WIN_BEATS(WIN_BEATS), .N_ENT(N_ENT), .PORT_W(PORT_W),
      .WORD_AW(WORD_AW), .ADDR_W(ADDR_W)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
      .pat_o(pat_flat), .msk_o(msk_flat), .trace_en_o(trace_en), .drop_mode_o(drop_mode),
      .tport_o(cfg_tport), .ent_en_o(ent_en)
   );

   assign buf_wr = (st == ST_FILL) && in_valid;

   trc_hold_buf #(.DW(DW), .DEPTH(WIN_BEATS), .IDX_W(CNT_W)) buf_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(buf_wr), .wr_idx_i(wcnt), .wr_data_i(in_data),
      .wr_sop_i(in_sop), .wr_eop_i(in_eop), .rd_idx_i(rcnt), .rd_data_o(rd_data),
      .rd_sop_o(rd_sop), .rd_eop_o(rd_eop), .win_o(win)
   );

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      trc_entry_cmp #(.DW(DW), .WIN_BEATS(WIN_BEATS)) cmp_i (
         .win_i(win), .pat_i(pat_flat[e*WB +: WB]), .msk_i(msk_flat[e*WB +: WB]),
         .en_i(ent_en[e]), .hit_o(hit[e])
      );
   end

   assign do_match = trace_en && (|hit);
   assign do_drop  = do_match && drop_mode;
   assign dec_stb  = (st == ST_DEC);

   always_comb begin
      pkt_done = 1'b0;
      case (st)
         ST_EMIT: pkt_done = out_ready && (rcnt == wcnt - CNT_W'(1)) && eop_held;
         ST_PASS: pkt_done = in_valid && out_ready && in_eop;
         ST_DISC: pkt_done = eop_held || (in_valid && in_eop);
         default: pkt_done = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_FILL;
         wcnt     <= '0;
         rcnt     <= '0;
         eop_held <= 1'b0;
         dec_copy <= 1'b0;
         tport_q  <= '0;
      end else begin
         case (st)
            ST_FILL: if (in_valid) begin
               wcnt <= wcnt + CNT_W'(1);
               if (in_eop) eop_held <= 1'b1;
               if (in_eop || wcnt == CNT_W'(WIN_BEATS - 1)) st <= ST_DEC;
            end
            ST_DEC: begin
               dec_copy <= do_match && !drop_mode;
               tport_q  <= cfg_tport;
               st       <= do_drop ? ST_DISC : ST_EMIT;
            end
            ST_EMIT: if (out_ready) begin
               rcnt <= rcnt + CNT_W'(1);
               if (rcnt == wcnt - CNT_W'(1)) st <= ST_PASS;
            end
            default: ;
         endcase
         if (pkt_done) begin
            st       <= ST_FILL;
            wcnt     <= '0;
            rcnt     <= '0;
            eop_held <= 1'b0;
            dec_copy <= 1'b0;
         end
      end
   end

   assign in_ready  = (st == ST_FILL) || ((st == ST_PASS) && out_ready) ||
                      ((st == ST_DISC) && !eop_held);
   assign out_valid = (st == ST_EMIT) || ((st == ST_PASS) && in_valid);
   assign out_data  = (st == ST_EMIT) ? rd_data : in_data;
   assign out_sop   = (st == ST_EMIT) ? rd_sop  : in_sop;
   assign out_eop   = (st == ST_EMIT) ? rd_eop  : in_eop;
   assign out_copy  = (st == ST_EMIT) && rd_sop && dec_copy;
   assign out_tport = out_copy ? tport_q : '0;

endmodule

// File: rtl/trc_filter_chk.sv
module trc_filter_chk #(
   parameter int unsigned DW     = 32,
   parameter int unsigned PORT_W = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DW-1:0]     out_data,
   input logic              out_sop,
   input logic              out_copy,
   input logic [PORT_W-1:0] out_tport,
   input logic              dec_stb
);

   // R9: sideband only on the start beat
   a_r9_side_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_sop |-> !out_copy && out_tport == '0);

   // R10: a stalled beat holds still
   a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_copy));

   // R1: the start beat follows a decision cycle
   a_r1_after_decision: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid && out_sop) |-> $past(dec_stb));

   // R1: no input is taken while the start beat waits
   a_r1_input_held: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sop |-> !in_ready);

   // R1: nothing leaves during the decision cycle
   a_r1_dec_silent: assert property (@(posedge clk) disable iff (!rst_n)
      dec_stb |-> !out_valid);

endmodule

bind trc_ingress_filter trc_filter_chk #(.DW(DW), .PORT_W(PORT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
   .out_copy(out_copy), .out_tport(out_tport), .dec_stb(dec_stb)
);

// File: tb/trc_ingress_filter_tb_top.sv
module trc_ingress_filter_tb_top;

   localparam int CLK_P = 10;
   localparam int SMP   = CLK_P / 2 - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready, out_valid, out_sop, out_eop, out_copy;
   logic        out_ready = 1'b1;
   logic [31:0] out_data;
   logic [3:0]  out_tport;

   trc_ingress_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
      .out_eop(out_eop), .out_copy(out_copy), .out_tport(out_tport)
   );

   always #(CLK_P/2) clk = ~clk;

   int nchk = 0, nfail = 0, cyc = 0;
   bit done = 0, rand_rdy = 0;

   // bench mirror of the configuration
   logic [31:0] m_pat [4][5];
   logic [31:0] m_msk [4][5];
   bit          m_en, m_drop;
   logic [3:0]  m_tp, m_ent;

   logic [31:0] pk [$];
   logic [38:0] eq [$];
   string       eq_req [$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         check(0, "WDG", "watchdog expired", 64'(cyc), 0);
         summary();
         $finish;
      end
   end

   always @(negedge clk) out_ready <= rand_rdy ? ($urandom % 3 != 0) : 1'b1;

   // monitor: compare every output handshake against the reference queue
   bit          stall_prev = 0;
   logic [38:0] prev_beat;
   always begin
      @(negedge clk);
      #(SMP);
      if (rst_n) begin
         if (stall_prev)
            check(out_valid && {out_sop, out_eop, out_copy, out_tport, out_data} == prev_beat,
                  "R10", "stalled beat changed", {out_valid, out_sop, out_eop, out_copy, out_tport, out_data},
                  {1'b1, prev_beat});
         if (out_valid && out_ready) begin
            if (eq.size() == 0)
               check(0, "R6", "unexpected output beat", {out_sop, out_eop, out_copy, out_tport, out_data}, 0);
            else begin
               logic [38:0] e;
               string r;
               e = eq.pop_front();
               r = eq_req.pop_front();
               check({out_sop, out_eop, out_copy, out_tport, out_data} == e, r, "output beat",
                     {out_sop, out_eop, out_copy, out_tport, out_data}, e);
            end
         end
         stall_prev = out_valid && !out_ready;
         prev_beat  = {out_sop, out_eop, out_copy, out_tport, out_data};
      end
   end

   task automatic cfg_wr(input int a, input logic [31:0] d);
      cfg_we = 1; cfg_addr = 7'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
      if (a == 64) begin
         m_en = d[0]; m_drop = d[1]; m_tp = d[11:8]; m_ent = d[19:16];
      end else if ((a % 8) < 5) begin
         if (((a / 8) % 2) == 0) m_pat[a/16][a%8] = d;
         else                    m_msk[a/16][a%8] = d;
      end
   endtask

   task automatic ctl(input bit en, input bit drop, input int tp, input int ent);
      cfg_wr(64, (32'(ent) << 16) | (32'(tp) << 8) | (32'(drop) << 1) | 32'(en));
   endtask

   task automatic mk_pkt(input int len);
      pk = {};
      for (int i = 0; i < len; i++) pk.push_back($urandom | 32'h1);
   endtask

   // reference decision, written from R2/R3/R4/R8
   task automatic expect_pkt(input string req);
      bit hit = 0, cp;
      for (int e = 0; e < 4; e++) begin
         if (m_ent[e]) begin
            bit ok = 1;
            for (int w = 0; w < 5; w++) begin
               logic [31:0] b;
               b = (w < pk.size()) ? pk[w] : 32'h0;
               if (((b ^ m_pat[e][w]) & m_msk[e][w]) != 0) ok = 0;
            end
            if (ok) hit = 1;
         end
      end
      hit = hit && m_en;
      if (hit && m_drop) return;
      cp = hit;
      for (int i = 0; i < pk.size(); i++) begin
         bit s;
         s = (i == 0);
         eq.push_back({s, i == pk.size() - 1, s && cp, (s && cp) ? m_tp : 4'h0, pk[i]});
         eq_req.push_back(req);
      end
   endtask

   task automatic push_beat(input logic [31:0] d, input bit s, input bit e);
      bit acc = 0;
      in_valid = 1; in_data = d; in_sop = s; in_eop = e;
      while (!acc) begin
         #(SMP);
         acc = in_ready;
         @(negedge clk);
      end
      in_valid = 0; in_sop = 0; in_eop = 0;
   endtask

   task automatic drive(input int from, input int to);
      for (int i = from; i < to; i++) push_beat(pk[i], i == 0, i == pk.size() - 1);
   endtask

   task automatic send(input int len, input string req);
      if (len > 0) mk_pkt(len);
      expect_pkt(req);
      drive(0, pk.size());
   endtask

   task automatic drain();
      while (eq.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      for (int e = 0; e < 4; e++) for (int w = 0; w < 5; w++) begin
         m_pat[e][w] = 0; m_msk[e][w] = 0;
      end
      m_en = 0; m_drop = 0; m_tp = 0; m_ent = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #(SMP);
      check(out_valid == 0, "R13", "out_valid after reset", 64'(out_valid), 0);
      check(in_ready == 1, "R13", "in_ready after reset", 64'(in_ready), 1);
      @(negedge clk);

      // R13: reset configuration tags nothing
      send(7, "R13");
      drain();

      // R8: entry fits everything but tracing is off
      ctl(0, 0, 9, 4'b0001);
      send(8, "R8");
      send(2, "R8");
      drain();

      // R5 R9: copy of every packet to port 9
      ctl(1, 0, 9, 4'b0001);
      send(8, "R5 R9");
      send(5, "R5");
      send(1, "R5");
      drain();

      // R2 R12 R7: masked pattern on window word 2
      cfg_wr(2, 32'hABCD_0000);
      cfg_wr(10, 32'hFFFF_0000);
      ctl(1, 0, 3, 4'b0001);
      mk_pkt(6); pk[2] = 32'hABCD_1234; send(0, "R2 R12");
      mk_pkt(6); pk[2] = 32'hABCE_0000; send(0, "R7");
      mk_pkt(3); pk[2] = 32'hABCD_FFFF; send(0, "R2");
      drain();

      // R3: disabled entry ignored, enabled ones OR-ed
      cfg_wr(20, 32'h5A5A_5A5A);
      cfg_wr(28, 32'hFFFF_FFFF);
      ctl(1, 0, 6, 4'b0010);
      mk_pkt(7); pk[2] = 32'hABCD_0001; send(0, "R3");
      mk_pkt(7); pk[4] = 32'h5A5A_5A5A; send(0, "R3");
      ctl(1, 0, 6, 4'b0011);
      mk_pkt(7); pk[2] = 32'hABCD_0001; send(0, "R3");
      drain();

      // R4: short packets compare missing words as zero
      cfg_wr(35, 32'h0);
      cfg_wr(43, 32'hFFFF_FFFF);
      ctl(1, 0, 12, 4'b0100);
      send(2, "R4");
      send(3, "R4");
      mk_pkt(4); pk[3] = 32'h0000_0100; send(0, "R4 R7");
      drain();

      // R6: drop mode
      ctl(1, 1, 12, 4'b0100);
      send(2, "R6");
      mk_pkt(9); pk[3] = 0; send(0, "R6");
      mk_pkt(6); pk[3] = 32'h7; send(0, "R6 R7");
      drain();
      check(eq.size() == 0, "R6", "reference queue empty", 64'(eq.size()), 0);

      // R1 R11: decision timing and pass-through
      cfg_wr(10, 32'h0);
      ctl(1, 0, 5, 4'b0001);
      mk_pkt(7);
      expect_pkt("R1 R11");
      drive(0, 5);
      #(SMP);
      check(out_valid == 0, "R1", "valid in decision cycle", 64'(out_valid), 0);
      @(negedge clk);
      #(SMP);
      check(out_valid && out_sop, "R1", "start beat after decision", 64'({out_valid, out_sop}), 3);
      @(negedge clk);
      repeat (8) @(negedge clk);
      #(SMP);
      check(out_valid == 0 && in_ready == 1, "R11", "idle pass-through", 64'({out_valid, in_ready}), 1);
      @(negedge clk);
      in_valid = 1; in_data = pk[5];
      #(SMP);
      check(out_valid == 1 && out_data == pk[5], "R11", "same-cycle pass-through",
            64'({out_valid, out_data}), 64'({1'b1, pk[5]}));
      @(negedge clk);
      in_valid = 0;
      drive(6, 7);
      drain();

      // R10: random backpressure, copy then drop
      rand_rdy = 1;
      ctl(1, 0, 10, 4'b0010);
      for (int n = 0; n < 25; n++) begin
         mk_pkt(1 + $urandom % 9);
         if (pk.size() > 4 && ($urandom % 2 == 1)) pk[4] = 32'h5A5A_5A5A;
         send(0, "R10");
      end
      drain();
      ctl(1, 1, 10, 4'b0010);
      for (int n = 0; n < 25; n++) begin
         mk_pkt(1 + $urandom % 9);
         if (pk.size() > 4 && ($urandom % 2 == 1)) pk[4] = 32'h5A5A_5A5A;
         send(0, "R10 R6");
      end
      drain();
      rand_rdy = 0;
      check(eq.size() == 0, "R10", "all expected beats seen", 64'(eq.size()), 0);

      done = 1;
      summary();
      $finish;
   end

endmodule